// File: doc/BRIEF.md
# Circular Queue Pointer Manager

This block keeps the producer and consumer positions of a circular queue whose entries live in memory and whose length is a power of two. Each position is an index plus one wrap bit. The wrap bit sits directly above the index, at a bit position chosen at run time by a programmed log2 length. Agents that add or remove entries pulse increment strobes. Software-style register writes can load either position directly.

From the two positions the block produces registered full and empty flags and the byte address of the current producer and consumer entries. The consumer word also carries a seven-bit command error code in its upper bits. Consumer increments never disturb that code. The producer word keeps an overflow marker in its top bit.

Increments the queue cannot honour are dropped: a producer increment while full, or a consumer increment while empty. Each such drop sets a sticky flag for that side.

Top module: `cq_ptr_mgr`

## Requirements
- R1: While reset is held, at the next rising edge both position words become 0, empty becomes 1, and full, both sticky misuse flags and both entry addresses become 0.
- R2: With L the effective log2 length, a producer increment sets bits L:0 of the producer word to their old value plus one, modulo 2^(L+1). The wrap bit (bit L) therefore toggles when the index rolls over. Bit 31 is kept. The result appears after the next rising edge.
- R3: A consumer increment replaces only bits L:0 of the consumer word with their old value plus one, modulo 2^(L+1). The error field in bits 30:24 is left unchanged.
- R4: `empty` is 1 exactly when bits L:0 of the two position words are equal.
- R5: `full` is 1 exactly when the two indices (bits L-1:0) are equal and the wrap bits (bit L) differ.
- R6: A producer increment while full, or a consumer increment while empty, with no write to the same word in that cycle, leaves the word unchanged. It sets that side's sticky flag, which stays set until reset.
- R7: A write loads a position word, keeping only bits L:0 plus bit 31 (producer) or bits 30:24 (consumer); all other bits read 0. A write takes precedence over an increment of the same word in the same cycle.
- R8: An error strobe stores its 7-bit code in consumer bits 30:24. The codes are 0 none, 1 illegal command, 2 abort and 3 invalidation sync error. The strobe overrides the field value of a consumer write made in the same cycle.
- R9: Each entry address equals the base address with bits 5:0 cleared, plus 2^ENTRY_LG (16 by default) times bits L-1:0 of the position word, modulo 2^ADDR_W.
- R10: A change of the programmed log2 length re-masks both stored words to the new width at the next edge. Values above MAX_LOG2 (19) act as 19.
- R11: Producer and consumer increments in the same cycle both take effect when each is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_log2size | input | L2_W (5) | Programmed log2 queue length |
| base_addr | input | ADDR_W (52) | Queue base byte address |
| prod_wr_en | input | 1 | Load the producer word |
| prod_wr_data | input | 32 | Producer write value |
| cons_wr_en | input | 1 | Load the consumer word |
| cons_wr_data | input | 32 | Consumer write value |
| prod_inc | input | 1 | Producer advance strobe |
| cons_inc | input | 1 | Consumer advance strobe |
| err_set | input | 1 | Store a command error code |
| err_code | input | 7 | Error code to store |
| prod_val | output | 32 | Producer word |
| cons_val | output | 32 | Consumer word including error field |
| full | output | 1 | Queue full |
| empty | output | 1 | Queue empty |
| prod_addr | output | ADDR_W (52) | Address of the producer entry |
| cons_addr | output | ADDR_W (52) | Address of the consumer entry |
| prod_overrun | output | 1 | Sticky: producer advance refused |
| cons_underrun | output | 1 | Sticky: consumer advance refused |

## Verification
Every result is due one rising edge after the stimulus that causes it: the position words, the flags and both addresses are all registered from the same next-state values. The one exception is the reset value, which is also taken at an edge. The bench drives each stimulus just after a falling edge and compares all outputs at the following falling edge. Its behavioural model advances by exactly one step per cycle, so one register stage is counted between drive and sample. The refusal decision uses the state held before the edge under the log2 length in force during that cycle, and the model follows the same rule.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int unsigned CQ_WORD_W  = 32;
  localparam int unsigned CQ_ERR_LSB = 24;
  localparam int unsigned CQ_ERR_W   = 7;
  localparam int unsigned CQ_OVF_BIT = 31;

  localparam logic [CQ_WORD_W-1:0] CQ_CONS_KEEP = 32'h7F00_0000;
  localparam logic [CQ_WORD_W-1:0] CQ_PROD_KEEP = 32'h8000_0000;

  typedef enum logic [CQ_ERR_W-1:0] {
    CQ_ERR_NONE    = 7'd0,
    CQ_ERR_ILLEGAL = 7'd1,
    CQ_ERR_ABORT   = 7'd2,
    CQ_ERR_SYNC    = 7'd3
  } cq_err_e;

  // mask covering index plus wrap bit for a given log2 length
  function automatic logic [CQ_WORD_W-1:0] cq_span(input int unsigned l2);
    return (32'd1 << (l2 + 1)) - 32'd1;
  endfunction
endpackage

// File: rtl/cq_occupancy.sv
module cq_occupancy
  import cq_pkg::*;
#(
  parameter int unsigned L2_W = 5
) (
  input  logic [CQ_WORD_W-1:0] ptr_a,
  input  logic [CQ_WORD_W-1:0] ptr_b,
  input  logic [L2_W-1:0]      log2_eff,
  output logic                 is_full,
  output logic                 is_empty
);
  logic [CQ_WORD_W-1:0] span;
  logic [CQ_WORD_W-1:0] wrap_bit;
  logic [CQ_WORD_W-1:0] diff;

  always_comb begin
    span     = cq_span(32'(log2_eff));
    wrap_bit = 32'd1 << log2_eff;
    diff     = (ptr_a ^ ptr_b) & span;
    is_empty = (diff == '0);
    is_full  = (diff == wrap_bit);
  end
endmodule

// File: rtl/cq_ptr_unit.sv
module cq_ptr_unit
  import cq_pkg::*;
#(
  parameter int unsigned          L2_W      = 5,
  parameter int unsigned          MAX_LOG2  = 19,
  parameter logic [CQ_WORD_W-1:0] KEEP_MASK = 32'h0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [L2_W-1:0]      log2_eff,
  input  logic                 wr_en,
  input  logic [CQ_WORD_W-1:0] wr_data,
  input  logic                 inc,
  input  logic                 blocked,
  input  logic                 fld_ld,
  input  logic [CQ_WORD_W-1:0] fld_val,
  output logic [CQ_WORD_W-1:0] ptr_q,
  output logic [CQ_WORD_W-1:0] ptr_d,
  output logic                 misuse
);
  localparam logic [CQ_WORD_W-1:0] SPAN_MAX = (32'd1 << (MAX_LOG2 + 1)) - 32'd1;

  logic [CQ_WORD_W-1:0] span;
  logic [CQ_WORD_W-1:0] bumped;
  logic [CQ_WORD_W-1:0] picked;
  logic [CQ_WORD_W-1:0] shaped;

  always_comb begin
    span   = cq_span(32'(log2_eff));
    // only the index-plus-wrap slice advances; upper fields ride along
    bumped = (ptr_q & ~span) | ((ptr_q + 32'd1) & span);
    if (wr_en)
      picked = wr_data;
    else if (inc && !blocked)
      picked = bumped;
    else
      picked = ptr_q;
    shaped = picked & (span | KEEP_MASK);
    ptr_d  = fld_ld ? ((shaped & ~KEEP_MASK) | (fld_val & KEEP_MASK)) : shaped;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      misuse <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      if (inc && blocked && !wr_en)
        misuse <= 1'b1;
    end
  end

  a_r6_refused_hold: assert property (@(posedge clk) disable iff (rst)
    (inc && blocked && !wr_en && !fld_ld && $stable(log2_eff)) |=> (ptr_q == $past(ptr_q)));

  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    misuse |=> misuse);

  a_r3_field_kept: assert property (@(posedge clk) disable iff (rst)
    (inc && !wr_en && !fld_ld) |=> ((ptr_q & KEEP_MASK) == $past(ptr_q & KEEP_MASK)));

  a_r10_in_width: assert property (@(posedge clk) disable iff (rst)
    ((ptr_q & ~(SPAN_MAX | KEEP_MASK)) == '0));

  a_r10_remask: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !inc && !fld_ld) |=> (ptr_q == $past(ptr_q & (span | KEEP_MASK))));
endmodule

// File: rtl/cq_entry_addr.sv
module cq_entry_addr
  import cq_pkg::*;
#(
  parameter int unsigned L2_W     = 5,
  parameter int unsigned ADDR_W   = 52,
  parameter int unsigned BASE_LSB = 6,
  parameter int unsigned ENTRY_LG = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    base,
  input  logic [CQ_WORD_W-1:0] ptr,
  input  logic [L2_W-1:0]      log2_eff,
  output logic [ADDR_W-1:0]    entry_addr
);
  localparam logic [ADDR_W-1:0] BASE_KEEP = {ADDR_W{1'b1}} << BASE_LSB;

  logic [CQ_WORD_W-1:0] idx;
  logic [ADDR_W-1:0]    offset;

  always_comb begin
    idx    = ptr & ((32'd1 << log2_eff) - 32'd1);
    offset = ADDR_W'(idx) << ENTRY_LG;
  end

  always_ff @(posedge clk) begin
    if (rst)
      entry_addr <= '0;
    else
      entry_addr <= (base & BASE_KEEP) + offset;
  end

  a_r9_entry_aligned: assert property (@(posedge clk) disable iff (rst)
    (entry_addr[ENTRY_LG-1:0] == '0));
endmodule

// File: rtl/cq_ptr_mgr.sv
module cq_ptr_mgr
  import cq_pkg::*;
#(
  parameter int unsigned L2_W     = 5,
  parameter int unsigned MAX_LOG2 = 19,
  parameter int unsigned ADDR_W   = 52,
  parameter int unsigned BASE_LSB = 6,
  parameter int unsigned ENTRY_LG = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [L2_W-1:0]   cfg_log2size,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              prod_wr_en,
  input  logic [31:0]       prod_wr_data,
  input  logic              cons_wr_en,
  input  logic [31:0]       cons_wr_data,
  input  logic              prod_inc,
  input  logic              cons_inc,
  input  logic              err_set,
  input  logic [6:0]        err_code,
  output logic [31:0]       prod_val,
  output logic [31:0]       cons_val,
  output logic              full,
  output logic              empty,
  output logic [ADDR_W-1:0] prod_addr,
  output logic [ADDR_W-1:0] cons_addr,
  output logic              prod_overrun,
  output logic              cons_underrun
);
  localparam int unsigned NSIDE = 2;   // 0: producer, 1: consumer
  localparam logic [L2_W-1:0] L2_CAP = L2_W'(MAX_LOG2);

  logic [L2_W-1:0]      log2_eff;
  logic [NSIDE-1:0]     wr_en_v, inc_v, blk_v, fld_ld_v, misuse_v;
  logic [CQ_WORD_W-1:0] wr_dat_v [NSIDE];
  logic [CQ_WORD_W-1:0] fld_v    [NSIDE];
  logic [CQ_WORD_W-1:0] ptr_q_v  [NSIDE];
  logic [CQ_WORD_W-1:0] ptr_d_v  [NSIDE];
  logic [ADDR_W-1:0]    addr_v   [NSIDE];
  logic                 cur_full, cur_empty, nxt_full, nxt_empty;

  assign log2_eff = (cfg_log2size > L2_CAP) ? L2_CAP : cfg_log2size;

  assign wr_en_v  = {cons_wr_en, prod_wr_en};
  assign inc_v    = {cons_inc, prod_inc};
  assign blk_v    = {cur_empty, cur_full};
  assign fld_ld_v = {err_set, 1'b0};
  assign wr_dat_v[0] = prod_wr_data;
  assign wr_dat_v[1] = cons_wr_data;
  assign fld_v[0]    = '0;
  assign fld_v[1]    = {1'b0, err_code, 24'd0};

  cq_occupancy #(.L2_W(L2_W)) u_occ_now (
    .ptr_a(ptr_q_v[0]), .ptr_b(ptr_q_v[1]), .log2_eff(log2_eff),
    .is_full(cur_full), .is_empty(cur_empty)
  );

  cq_occupancy #(.L2_W(L2_W)) u_occ_next (
    .ptr_a(ptr_d_v[0]), .ptr_b(ptr_d_v[1]), .log2_eff(log2_eff),
    .is_full(nxt_full), .is_empty(nxt_empty)
  );

  for (genvar gi = 0; gi < NSIDE; gi++) begin : g_side
    cq_ptr_unit #(
      .L2_W(L2_W), .MAX_LOG2(MAX_LOG2),
      .KEEP_MASK((gi == 1) ? CQ_CONS_KEEP : CQ_PROD_KEEP)
    ) u_ptr (
      .clk(clk), .rst(rst), .log2_eff(log2_eff),
      .wr_en(wr_en_v[gi]), .wr_data(wr_dat_v[gi]),
      .inc(inc_v[gi]), .blocked(blk_v[gi]),
      .fld_ld(fld_ld_v[gi]), .fld_val(fld_v[gi]),
      .ptr_q(ptr_q_v[gi]), .ptr_d(ptr_d_v[gi]), .misuse(misuse_v[gi])
    );

    cq_entry_addr #(
      .L2_W(L2_W), .ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .ENTRY_LG(ENTRY_LG)
    ) u_addr (
      .clk(clk), .rst(rst), .base(base_addr), .ptr(ptr_d_v[gi]),
      .log2_eff(log2_eff), .entry_addr(addr_v[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      full  <= nxt_full;
      empty <= nxt_empty;
    end
  end

  assign prod_val      = ptr_q_v[0];
  assign cons_val      = ptr_q_v[1];
  assign prod_addr     = addr_v[0];
  assign cons_addr     = addr_v[1];
  assign prod_overrun  = misuse_v[0];
  assign cons_underrun = misuse_v[1];

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  a_r8_code_stored: assert property (@(posedge clk) disable iff (rst)
    err_set |=> (cons_val[30:24] == $past(err_code)));

  a_r2_overrun_needs_full: assert property (@(posedge clk) disable iff (rst)
    $rose(prod_overrun) |-> $past(prod_inc && cur_full));
endmodule

// File: tb/test_cq_ptr_mgr.sv
module test_cq_ptr_mgr;
  localparam int CLK_P = 10;
  localparam int unsigned MAXL = 19;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  cfg_log2size = 5'd1;
  logic [51:0] base_addr = '0;
  logic        prod_wr_en = 0, cons_wr_en = 0, prod_inc = 0, cons_inc = 0, err_set = 0;
  logic [31:0] prod_wr_data = '0, cons_wr_data = '0;
  logic [6:0]  err_code = '0;
  logic [31:0] prod_val, cons_val;
  logic        full, empty, prod_overrun, cons_underrun;
  logic [51:0] prod_addr, cons_addr;

  cq_ptr_mgr i_cq_ptr_mgr (
    .clk(clk), .rst(rst), .cfg_log2size(cfg_log2size), .base_addr(base_addr),
    .prod_wr_en(prod_wr_en), .prod_wr_data(prod_wr_data),
    .cons_wr_en(cons_wr_en), .cons_wr_data(cons_wr_data),
    .prod_inc(prod_inc), .cons_inc(cons_inc), .err_set(err_set), .err_code(err_code),
    .prod_val(prod_val), .cons_val(cons_val), .full(full), .empty(empty),
    .prod_addr(prod_addr), .cons_addr(cons_addr),
    .prod_overrun(prod_overrun), .cons_underrun(cons_underrun)
  );

  always #(CLK_P/2) clk = ~clk;

  int  n_run = 0, n_fail = 0;
  bit  done = 0;
  logic [31:0] mp = '0, mc = '0;
  bit  mo = 0, mu = 0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic int unsigned eff_l(input int unsigned c);
    return (c > MAXL) ? MAXL : c;
  endfunction

  function automatic logic [63:0] exp_addr(input logic [31:0] p, input int unsigned wrapb);
    logic [63:0] bm;
    bm = {12'd0, base_addr} & 64'h000F_FFFF_FFFF_FFC0;
    return (bm + ({32'd0, p & (wrapb - 1)} << 4)) & 64'h000F_FFFF_FFFF_FFFF;
  endfunction

  // one clock of stimulus; model steps; outputs compared at next falling edge
  task automatic cyc(input string ph, input bit pw, input logic [31:0] pwd,
                     input bit cw, input logic [31:0] cwd, input bit pi, input bit ci,
                     input bit es, input logic [6:0] ec);
    int unsigned L, span, wrapb;
    logic [31:0] d, np, nc;
    bit cf, ce;
    prod_wr_en = pw; prod_wr_data = pwd; cons_wr_en = cw; cons_wr_data = cwd;
    prod_inc = pi; cons_inc = ci; err_set = es; err_code = ec;
    L = eff_l(32'(cfg_log2size));
    span = (32'd1 << (L + 1)) - 1;
    wrapb = 32'd1 << L;
    d = (mp ^ mc) & span;
    cf = (d == wrapb);
    ce = (d == 0);
    if (pw) np = pwd;
    else if (pi && !cf) np = ((mp + 1) & span) | (mp & ~span);
    else np = mp;
    np = np & (span | 32'h8000_0000);
    if (cw) nc = cwd;
    else if (ci && !ce) nc = ((mc + 1) & span) | (mc & ~span);
    else nc = mc;
    nc = nc & (span | 32'h7F00_0000);
    if (es) nc = (nc & ~32'h7F00_0000) | ({25'd0, ec} << 24);
    if (pi && !pw && cf) mo = 1;
    if (ci && !cw && ce) mu = 1;
    mp = np; mc = nc;
    @(negedge clk);
    chk({ph, " R2 prod_val"}, 64'(prod_val), 64'(mp));
    chk({ph, " R3 cons_val"}, 64'(cons_val), 64'(mc));
    chk({ph, " R4 empty"}, 64'(empty), 64'(((mp ^ mc) & span) == 0));
    chk({ph, " R5 full"}, 64'(full), 64'(((mp ^ mc) & span) == wrapb));
    chk({ph, " R6 overrun"}, 64'(prod_overrun), 64'(mo));
    chk({ph, " R6 underrun"}, 64'(cons_underrun), 64'(mu));
    chk({ph, " R9 prod_addr"}, {12'd0, prod_addr}, exp_addr(mp, wrapb));
    chk({ph, " R9 cons_addr"}, {12'd0, cons_addr}, exp_addr(mc, wrapb));
    prod_wr_en = 0; cons_wr_en = 0; prod_inc = 0; cons_inc = 0; err_set = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    prod_wr_en = 0; cons_wr_en = 0; prod_inc = 0; cons_inc = 0; err_set = 0;
    repeat (2) @(negedge clk);
    chk("R1 reset prod_val", 64'(prod_val), 0);
    chk("R1 reset cons_val", 64'(cons_val), 0);
    chk("R1 reset empty", 64'(empty), 1);
    chk("R1 reset full", 64'(full), 0);
    chk("R1 reset sticky", {62'd0, prod_overrun, cons_underrun}, 0);
    chk("R1 reset addr", {12'd0, prod_addr | cons_addr}, 0);
    mp = '0; mc = '0; mo = 0; mu = 0;
    rst = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: got %0d cycles expected fewer", 150000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int l2 = 1; l2 <= 5; l2++) begin
      cfg_log2size = 5'(l2);
      base_addr = {$urandom, $urandom}[51:0];
      do_reset();
      for (int k = 0; k < (1 << l2); k++) cyc("fill", 0, 0, 0, 0, 1, 0, 0, 0);
      chk("R5 full after fill", 64'(full), 1);
      cyc("overfill", 0, 0, 0, 0, 1, 0, 0, 0);
      chk("R6 overrun sticky set", 64'(prod_overrun), 1);
      for (int k = 0; k < (1 << l2); k++) cyc("drain", 0, 0, 0, 0, 0, 1, 0, 0);
      chk("R4 empty after drain", 64'(empty), 1);
      cyc("underrun", 0, 0, 0, 0, 0, 1, 0, 0);
      chk("R6 underrun sticky set", 64'(cons_underrun), 1);
      cyc("errset", 0, 0, 0, 0, 0, 0, 1, 7'd1);
      chk("R8 illegal code stored", 64'(cons_val[30:24]), 1);
      for (int k = 0; k < 3; k++) cyc("keep", 0, 0, 0, 0, 1, 0, 0, 0);
      for (int k = 0; k < 3; k++) cyc("keep", 0, 0, 0, 0, 0, 1, 0, 0);
      chk("R3 field survives increments", 64'(cons_val[30:24]), 1);
      for (int k = 0; k < 300; k++) begin
        logic [31:0] r;
        r = $urandom;
        cyc("rand", r[7:0] < 8'd6, $urandom, r[15:8] < 8'd6, $urandom,
            r[16] | r[18], r[17] | r[19], r[27:20] < 8'd10, 7'(r[29:28]));
      end
    end

    cfg_log2size = 5'd3;
    do_reset();
    cyc("R7 write", 1, 32'hFFFF_FFFF, 0, 0, 1, 0, 0, 0);
    chk("R7 producer write masked", 64'(prod_val), 64'h8000_000F);
    cyc("R7 cons write", 0, 0, 1, 32'hFFFF_FFFF, 0, 1, 1, 7'd2);
    chk("R8 strobe beats write field", 64'(cons_val), 64'h0200_000F);

    do_reset();
    for (int k = 0; k < 3; k++) cyc("R11 prep", 0, 0, 0, 0, 1, 0, 0, 0);
    cyc("R11 both", 0, 0, 0, 0, 1, 1, 0, 0);
    chk("R11 producer advanced", 64'(prod_val), 4);
    chk("R11 consumer advanced", 64'(cons_val), 1);

    cyc("R10 prep", 1, 32'h0000_000D, 0, 0, 0, 0, 0, 0);
    cfg_log2size = 5'd2;
    cyc("R10 shrink", 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 remask to new width", 64'(prod_val), 5);
    cfg_log2size = 5'd25;
    cyc("R10 cap", 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
    chk("R10 oversize length capped", 64'(prod_val), 64'h800F_FFFF);
    for (int k = 0; k < 20; k++) cyc("R10 big", 0, 0, 0, 0, k[0], ~k[0], 0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule